// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the device-side command decoder of a single-bank flash array. A host issues bus writes, each an address/data pair. The block checks them against fixed unlock patterns and turns complete sequences into word programming, sector erase, erase suspend/resume and reset operations. The array is a small internal memory. Program and erase times come from down-counters, so a whole operation can be exercised in a few dozen clock cycles.

While an embedded operation runs, any read returns a status byte instead of array data. Bit 7 is a data-polling bit. Bit 6 inverts on every read while the block is busy. Bit 5 flags a failed operation. Bit 3 tells whether the erase acceptance window has closed and erasure has begun. A sector erase opens a short acceptance window in which further sectors can be added before erasure starts. A running erase can be suspended, so that the other sectors can be read or programmed, and then resumed.

Top module: `flashCmdSeq`

## Requirements
- R1: After reset the block is in read mode, every array word holds FFh, and a read returns the addressed word combinationally on `rdData`.
- R2: The writes 555h/AAh, 2AAh/55h, 555h/A0h, then PA/PD start a program. After PROG_CYC cycles the word at PA holds its old value AND PD, and reads return array data again. The array word is `addr[5:0]`.
- R3: While a program runs, every read returns bit 7 = NOT PD[7], bit 6 = toggle, and bits 5..0 = 0.
- R4: Status bit 6 reads 0 on the first read of a busy period and inverts on each further read until the block is idle.
- R5: If PD has a 1 where the stored word has a 0, the program fails. Reads then return bit 7 = NOT PD[7], bit 6 = toggle, bit 5 = 1, and the other bits 0. This continues until a write of F0h, which returns the block to read mode. Other writes are ignored. The word keeps old AND PD.
- R6: The writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then SA/30h open an acceptance window of WIN_CYC cycles. The sector is `addr[5:4]`. During the window, status reads give bit 3 = 0 and bit 7 = 0. A 30h write in the window adds its sector and restarts the window.
- R7: When the window closes, erasing runs for ERASE_CYC cycles, with status bit 3 = 1 and bit 7 = 0. At the end, every word of each queued sector reads FFh and all other words are unchanged.
- R8: A write in the window whose data is neither 30h nor B0h cancels the erase and returns to read mode. B0h in the window is ignored.
- R9: B0h while erasing suspends the erase. While suspended, reads in queued sectors return 80h, reads elsewhere return array data, the remaining erase time is held, and a further B0h has no effect. A 30h write in suspended read mode resumes the erase for its remaining time. B0h in plain read mode has no effect.
- R10: While suspended, a program to a non-queued sector runs normally and the block returns to the suspended state. A program address in a queued sector discards the sequence, and so does an 80h erase setup.
- R11: A wrong address or data in any unlock or setup cycle discards the partial sequence and returns to read mode.
- R12: An F0h write in any command-entry state returns the block to read mode. F0h during a running program is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe, one per write cycle |
| rdEn | input | 1 | Bus read strobe; advances the status toggle |
| addr | input | ADDR_W | Word address for commands and reads |
| wrData | input | 8 | Command or program data |
| rdData | output | 8 | Array data or status byte |

## Verification
The checker assumes that the strobes and data are known from the first edge after reset, and that each `rdEn` high cycle is one read, so successive busy reads must show opposite toggle bits. It also assumes F0h is the only way out of a failed program, and that the suspend flag changes only on an erase/suspend boundary. The stimulus drives the strobes on falling edges and holds each one for exactly one rising edge. It waits well past PROG_CYC, WIN_CYC and ERASE_CYC before it reads a final result. It issues any write that must land inside the acceptance window within a few cycles of opening it.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  localparam logic [11:0] UNLOCK_ADR_A = 12'h555;
  localparam logic [11:0] UNLOCK_ADR_B = 12'h2AA;
  localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG     = 8'hA0;
  localparam logic [7:0]  CMD_ERASE    = 8'h80;
  localparam logic [7:0]  CMD_SECTOR   = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0]  CMD_RESET    = 8'hF0;

  typedef enum logic [3:0] {
    S_READ, S_KEY1, S_KEY2, S_ESETUP, S_KEY3, S_KEY4,
    S_PADDR, S_PROG, S_PFAIL, S_WIN, S_ERASE
  } ctrlStateT;

  typedef enum logic [2:0] {
    MODE_ARRAY, MODE_PROG, MODE_PFAIL, MODE_WIN, MODE_ERASE
  } statModeT;

  typedef struct packed {
    logic     latchProg;
    logic     commitProg;
    logic     markSector;
    logic     clearMask;
    logic     commitErase;
    statModeT mode;
    logic     susp;
  } ctrlStrobeT;

endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PROG_CYC  = 8,
  parameter int WIN_CYC   = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              progFail,
  input  logic              addrQueued,
  output ctrlStrobeT        stb
);

  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int EMAX = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int EW = $clog2(EMAX + 1);
  localparam logic [PW-1:0] PROG_LOAD  = PW'(PROG_CYC - 1);
  localparam logic [EW-1:0] WIN_LOAD   = EW'(WIN_CYC - 1);
  localparam logic [EW-1:0] ERASE_LOAD = EW'(ERASE_CYC - 1);

  ctrlStateT       state, nextState;
  logic            susp, goSusp, goResume, startErase;
  logic [PW-1:0]   progCnt;
  logic [EW-1:0]   eraseCnt;
  logic            keyA, keyB, atA;

  assign atA  = (addr == ADDR_W'(UNLOCK_ADR_A));
  assign keyA = atA && (wrData == CMD_KEY_A);
  assign keyB = (addr == ADDR_W'(UNLOCK_ADR_B)) && (wrData == CMD_KEY_B);

  always_comb begin
    nextState  = state;
    goSusp     = 1'b0;
    goResume   = 1'b0;
    startErase = 1'b0;
    stb        = '0;
    stb.susp   = susp;
    case (state)
      S_READ:   if (wrEn) begin
                  if (keyA) nextState = S_KEY1;
                  else if (susp && wrData == CMD_SECTOR) begin
                    nextState = S_ERASE;   // R9 resume
                    goResume  = 1'b1;
                  end
                end
      S_KEY1:   if (wrEn) nextState = keyB ? S_KEY2 : S_READ;  // R11
      S_KEY2:   if (wrEn) begin
                  if (atA && wrData == CMD_PROG) nextState = S_PADDR;
                  else if (atA && wrData == CMD_ERASE && !susp) nextState = S_ESETUP;
                  else nextState = S_READ;                       // R10, R11
                end
      S_ESETUP: if (wrEn) nextState = keyA ? S_KEY3 : S_READ;
      S_KEY3:   if (wrEn) nextState = keyB ? S_KEY4 : S_READ;
      S_KEY4:   if (wrEn) begin
                  if (wrData == CMD_SECTOR) begin
                    stb.markSector = 1'b1;
                    nextState      = S_WIN;
                  end else nextState = S_READ;
                end
      S_PADDR:  if (wrEn) begin
                  if (wrData == CMD_RESET || (susp && addrQueued)) nextState = S_READ; // R12, R10
                  else begin
                    stb.latchProg = 1'b1;
                    nextState     = S_PROG;
                  end
                end
      S_PROG:   if (progCnt == '0) begin
                  stb.commitProg = 1'b1;
                  nextState      = progFail ? S_PFAIL : S_READ;
                end
      S_PFAIL:  if (wrEn && wrData == CMD_RESET) nextState = S_READ;  // R5
      S_WIN:    if (wrEn) begin
                  if (wrData == CMD_SECTOR) stb.markSector = 1'b1;      // R6
                  else if (wrData != CMD_SUSPEND) begin                  // R8
                    stb.clearMask = 1'b1;
                    nextState     = S_READ;
                  end
                end else if (eraseCnt == '0) begin
                  startErase = 1'b1;
                  nextState  = S_ERASE;
                end
      S_ERASE:  if (eraseCnt == '0) begin
                  stb.commitErase = 1'b1;
                  stb.clearMask   = 1'b1;
                  nextState       = S_READ;
                end else if (wrEn && wrData == CMD_SUSPEND) begin
                  goSusp    = 1'b1;
                  nextState = S_READ;
                end
      default:  nextState = S_READ;
    endcase
    case (state)
      S_PROG:  stb.mode = MODE_PROG;
      S_PFAIL: stb.mode = MODE_PFAIL;
      S_WIN:   stb.mode = MODE_WIN;
      S_ERASE: stb.mode = MODE_ERASE;
      default: stb.mode = MODE_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_READ;
      susp     <= 1'b0;
      progCnt  <= '0;
      eraseCnt <= '0;
    end else begin
      state <= nextState;
      if (goSusp) susp <= 1'b1;
      else if (goResume) susp <= 1'b0;
      if (stb.latchProg) progCnt <= PROG_LOAD;
      else if (state == S_PROG && progCnt != '0) progCnt <= progCnt - 1'b1;
      if (stb.markSector) eraseCnt <= WIN_LOAD;
      else if (startErase) eraseCnt <= ERASE_LOAD;
      else if ((state == S_WIN || state == S_ERASE) && eraseCnt != '0)
        eraseCnt <= eraseCnt - 1'b1;
    end
  end

endmodule

// File: rtl/flashCmdData.sv
module flashCmdData
  import flashCmdPkg::*;
#(
  parameter int ARR_W = 6,
  parameter int SEC_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [ARR_W-1:0] idx,
  input  logic [7:0]       wrData,
  input  ctrlStrobeT       stb,
  output logic             progFail,
  output logic             addrQueued,
  output logic [7:0]       rdData
);

  localparam int WORDS     = 1 << ARR_W;
  localparam int NSEC      = 1 << SEC_W;
  localparam int SEC_WORDS = WORDS / NSEC;

  logic [7:0]       mem [WORDS];
  logic [ARR_W-1:0] progAdr;
  logic [7:0]       progDat;
  logic [NSEC-1:0]  queued;
  logic             tog;
  logic [SEC_W-1:0] sec;

  assign sec        = idx[ARR_W-1 -: SEC_W];
  assign addrQueued = queued[sec];
  assign progFail   = |(progDat & ~mem[progAdr]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;   // R1
    end else if (stb.commitProg) begin
      mem[progAdr] <= mem[progAdr] & progDat;             // R2
    end else if (stb.commitErase) begin
      for (int i = 0; i < WORDS; i++)
        if (queued[i / SEC_WORDS]) mem[i] <= 8'hFF;       // R7
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAdr <= '0;
      progDat <= '0;
      queued  <= '0;
      tog     <= 1'b0;
    end else begin
      if (stb.latchProg) begin
        progAdr <= idx;
        progDat <= wrData;
      end
      if (stb.clearMask) queued <= '0;
      else if (stb.markSector) queued <= queued | (NSEC'(1) << sec);
      if (stb.mode == MODE_ARRAY) tog <= 1'b0;            // R4
      else if (rdEn) tog <= ~tog;
    end
  end

  always_comb begin
    case (stb.mode)
      MODE_PROG:  rdData = {~progDat[7], tog, 6'b0};
      MODE_PFAIL: rdData = {~progDat[7], tog, 1'b1, 5'b0};
      MODE_WIN:   rdData = {1'b0, tog, 6'b0};
      MODE_ERASE: rdData = {1'b0, tog, 2'b0, 1'b1, 3'b0};
      default:    rdData = (stb.susp && queued[sec]) ? 8'h80 : mem[idx];
    endcase
  end

endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flashCmdPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ARR_W     = 6,
  parameter int SEC_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int WIN_CYC   = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  ctrlStrobeT stb;
  logic       progFail, addrQueued;

  flashCmdCtrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .progFail(progFail), .addrQueued(addrQueued), .stb(stb)
  );

  flashCmdData #(.ARR_W(ARR_W), .SEC_W(SEC_W)) u_data (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .idx(addr[ARR_W-1:0]), .wrData(wrData),
    .stb(stb), .progFail(progFail), .addrQueued(addrQueued), .rdData(rdData)
  );

endmodule

// File: rtl/flashCmdSeqChk.sv
module flashCmdSeqChk
  import flashCmdPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input ctrlStrobeT stb
);

  logic busy;
  assign busy = (stb.mode != MODE_ARRAY);

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busy && $past(rdEn && busy)) |-> (rdData[6] != $past(rdData[6])));

  // R3
  prog_status_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stb.mode == MODE_PROG) |-> (rdData[5:0] == 6'b0));

  // R6
  window_dq3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stb.mode == MODE_WIN) |-> (!rdData[3] && !rdData[7]));

  // R7
  erasing_dq3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stb.mode == MODE_ERASE) |-> (rdData[3] && !rdData[7]));

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode == MODE_PFAIL && !(wrEn && wrData == CMD_RESET)) |=> (stb.mode == MODE_PFAIL));

  // R9
  suspend_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.susp) |-> ($past(stb.mode) == MODE_ERASE));

  // R9
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.susp) |-> (stb.mode == MODE_ERASE));

endmodule

bind flashCmdSeq flashCmdSeqChk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .stb(stb)
);

// File: tb/flashCmdSeq_bench.sv
module flashCmdSeq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 40;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WAIT = 2'd2;

  // {op, requirement, address, data}
  localparam logic [25:0] VEC [VEC_N] = '{
    {OP_RD,   4'd1,  12'h010, 8'hFF},  // R1 erased after reset
    {OP_WR,   4'd2,  12'h555, 8'hAA},
    {OP_WR,   4'd2,  12'h2AA, 8'h55},
    {OP_WR,   4'd2,  12'h555, 8'hA0},
    {OP_WR,   4'd2,  12'h010, 8'h3C},
    {OP_RD,   4'd3,  12'h010, 8'h80},  // R3 busy, NOT PD7, toggle 0
    {OP_RD,   4'd4,  12'h010, 8'hC0},  // R4 toggle flips
    {OP_WAIT, 4'd2,  12'h000, 8'd12},
    {OP_RD,   4'd2,  12'h010, 8'h3C},  // R2 programmed
    {OP_WR,   4'd11, 12'h555, 8'hAA},
    {OP_WR,   4'd11, 12'h2AB, 8'h55},  // R11 wrong address
    {OP_WR,   4'd11, 12'h555, 8'hA0},
    {OP_WR,   4'd11, 12'h020, 8'h00},
    {OP_RD,   4'd11, 12'h020, 8'hFF},  // R11 nothing written
    {OP_WR,   4'd12, 12'h555, 8'hAA},
    {OP_WR,   4'd12, 12'h2AA, 8'h55},
    {OP_WR,   4'd12, 12'h000, 8'hF0},  // R12 abort
    {OP_WR,   4'd12, 12'h555, 8'hA0},
    {OP_WR,   4'd12, 12'h021, 8'h11},
    {OP_RD,   4'd12, 12'h021, 8'hFF},  // R12 not programmed
    {OP_WR,   4'd2,  12'h555, 8'hAA},
    {OP_WR,   4'd2,  12'h2AA, 8'h55},
    {OP_WR,   4'd2,  12'h555, 8'hA0},
    {OP_WR,   4'd2,  12'h021, 8'h81},
    {OP_RD,   4'd3,  12'h021, 8'h00},  // R3 NOT PD7 = 0
    {OP_WR,   4'd12, 12'h000, 8'hF0},  // R12 ignored while running
    {OP_RD,   4'd12, 12'h021, 8'h40},  // R12 still busy
    {OP_WAIT, 4'd2,  12'h000, 8'd12},
    {OP_RD,   4'd2,  12'h021, 8'h81},  // R2
    {OP_WR,   4'd5,  12'h555, 8'hAA},
    {OP_WR,   4'd5,  12'h2AA, 8'h55},
    {OP_WR,   4'd5,  12'h555, 8'hA0},
    {OP_WR,   4'd5,  12'h021, 8'h83},  // R5 bit 1 cannot rise
    {OP_WAIT, 4'd5,  12'h000, 8'd12},
    {OP_RD,   4'd5,  12'h021, 8'h20},  // R5 fail flag
    {OP_RD,   4'd5,  12'h021, 8'h60},  // R5 toggle continues
    {OP_WR,   4'd5,  12'h000, 8'hAA},  // R5 non-reset write ignored
    {OP_RD,   4'd5,  12'h021, 8'h20},
    {OP_WR,   4'd5,  12'h000, 8'hF0},
    {OP_RD,   4'd5,  12'h021, 8'h81}   // R5 word holds old AND PD
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  int          nChecks = 0;
  int          nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flashCmdSeq u_flashCmdSeq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkRd(input int req, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] got;
    rd(a, got);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL R%0d addr %h: got %h expected %h", req, a, got, exp);
    end
  endtask

  task automatic progSeq(input logic [11:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic eraseSeq(input logic [11:0] sa);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(sa, 8'h30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    for (int i = 0; i < VEC_N; i++) begin
      case (VEC[i][25:24])
        OP_WR:   wr(VEC[i][19:8], VEC[i][7:0]);
        OP_RD:   chkRd(int'(VEC[i][23:20]), VEC[i][19:8], VEC[i][7:0]);
        default: idle(int'(VEC[i][7:0]));
      endcase
    end

    // setup words in sectors 0 and 3
    progSeq(12'h035, 8'h11); idle(12);
    progSeq(12'h005, 8'h22); idle(12);
    progSeq(12'h001, 8'h55); idle(12);

    // R6 window, queue a second sector, R7 erase
    eraseSeq(12'h010);
    chkRd(6, 12'h010, 8'h00);   // R6 window, bit3 0, toggle 0
    wr(12'h030, 8'h30);
    chkRd(6, 12'h010, 8'h40);   // R6 window continues after queueing
    idle(18);
    chkRd(7, 12'h010, 8'h08);   // R7 erasing, bit3 1
    idle(50);
    chkRd(7, 12'h010, 8'hFF);   // R7 sector 1 erased
    chkRd(7, 12'h035, 8'hFF);   // R7 sector 3 erased
    chkRd(7, 12'h021, 8'h81);   // R7 sector 2 untouched
    chkRd(7, 12'h005, 8'h22);   // R7 sector 0 untouched

    // R8 cancel
    eraseSeq(12'h020);
    wr(12'h000, 8'hB0);
    chkRd(8, 12'h021, 8'h00);   // R8 B0 ignored in window
    wr(12'h000, 8'h12);
    chkRd(8, 12'h021, 8'h81);   // R8 back to read mode
    idle(60);
    chkRd(8, 12'h021, 8'h81);   // R8 nothing erased

    // R9 / R10 suspend
    eraseSeq(12'h000);
    idle(20);
    wr(12'h000, 8'hB0);
    chkRd(9, 12'h001, 8'h80);   // R9 queued sector reads suspended status
    chkRd(9, 12'h010, 8'hFF);   // R9 other sector reads array
    wr(12'h000, 8'hB0);
    idle(100);
    chkRd(9, 12'h001, 8'h80);   // R9 erase time held
    progSeq(12'h011, 8'h5A);
    chkRd(10, 12'h011, 8'h80);  // R10 program runs while suspended
    idle(12);
    chkRd(10, 12'h011, 8'h5A);  // R10 programmed
    chkRd(10, 12'h001, 8'h80);  // R10 back to suspended
    progSeq(12'h002, 8'h00);
    chkRd(10, 12'h011, 8'h5A);  // R10 program into queued sector discarded
    eraseSeq(12'h010);
    chkRd(10, 12'h010, 8'hFF);  // R10 erase setup discarded
    chkRd(10, 12'h001, 8'h80);  // R10 still suspended
    wr(12'h000, 8'h30);
    chkRd(9, 12'h001, 8'h08);   // R9 resumed
    idle(60);
    chkRd(9, 12'h001, 8'hFF);   // R9 erase completes
    chkRd(9, 12'h005, 8'hFF);
    chkRd(9, 12'h011, 8'h5A);
    wr(12'h000, 8'hB0);
    chkRd(9, 12'h011, 8'h5A);   // R9 B0 in read mode has no effect

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    chkRd(1, 12'h011, 8'hFF);   // R1 array back to FF
    chkRd(1, 12'h021, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule